// File: doc/BRIEF.md
# Dual-Alignment PWM Channel

This block is one 8-bit pulse-width modulation channel. A counter advances on a clock-enable tick and drives one output pin. The counter is compared against an active period value and an active duty value. In edge-aligned mode the counter runs upward and wraps, so each period lasts PER ticks. In center-aligned mode it runs up to PER and back down to zero, which gives a symmetric pulse and a period of 2×PER ticks.

A polarity input picks the level driven during the active part of the period. Software writes new period and duty values into shadow buffers at any time. The channel copies those buffers into its active registers only when the counter returns to zero, so a period that is already running never takes a torn value. Clearing the counter restarts the period at once. Dropping the enable parks the channel.

A typical use is a fixed-frequency drive whose duty is retuned on the fly. An example is a 12 MHz tick with PER=120 and DTY=60 in edge-aligned mode, which gives a 100 kHz square wave.

Top module: `pwm_align_chan`

## Requirements
- R1: In edge-aligned mode (`center`=0) with PER≥1, the counter steps 0,1,…,PER−1 on successive ticks and returns to 0 on the tick after PER−1, so a period is PER ticks.
- R2: The output is at the active level (equal to `pol`) while the count is below DTY and at the inactive level (`!pol`) otherwise. With `pol`=1 the high fraction is DTY/PER, and with `pol`=0 it is (PER−DTY)/PER.
- R3: In center-aligned mode (`center`=1) the counter rises from 0 to PER and then falls back to 1. It re-enters 0 going up on the next tick, so a period is 2×PER ticks and the count at the last tick of a period is 1.
- R4: In center-aligned mode the output is active while the count is below DTY on the rising half and while it is at most DTY on the falling half. The output therefore toggles once on each half, and the active time is 2×DTY ticks per period.
- R5: DTY≥PER keeps the output at the active level for the whole period. DTY=0 keeps it at the inactive level for the whole period, in both modes.
- R6: A pulse on `per_wr` or `dty_wr` stores the value in a shadow buffer. The active period and duty take the buffer values only when the counter goes to 0: at the wrap in edge-aligned mode and at the bottom of the fall in center-aligned mode. The period in progress finishes with the old values.
- R7: A `cnt_clr` pulse while enabled forces the counter to 0 on the next cycle and loads the buffers. The new period starts at the active level whenever DTY>0. `cnt_clr` wins over `tick`.
- R8: While `en`=0 the counter is held at 0, the output sits at the inactive level `!pol`, and the active registers follow the buffers.
- R9: The counter changes only on cycles where `tick`=1, or on a clear or disable.
- R10: After reset the counter is 0, both buffers and both active values are 0, and the output shows the inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable; one counter step per high cycle |
| en | input | 1 | Channel run enable |
| pol | input | 1 | Active output level |
| center | input | 1 | 1 = center-aligned up/down, 0 = edge-aligned up-count |
| cnt_clr | input | 1 | Pulse clears the counter and restarts the period |
| per_wr | input | 1 | Write strobe for the period buffer |
| per_in | input | W | Period value to buffer |
| dty_wr | input | 1 | Write strobe for the duty buffer |
| dty_in | input | W | Duty value to buffer |
| pwm_out | output | 1 | Waveform output |
| cnt_out | output | W | Current counter value |

## Verification
A table of settings drives whole periods in both alignments and both polarities. Each run measures three things: the level at the start of the period, the count of high cycles, and the counter value on the last and first ticks. These results separate a count that is off by one in either direction, a missing down-count turn, and a swapped polarity. The extreme duties (zero, equal to PER, above PER) and the smallest center period of one separate a strict compare from an inclusive one. Directed runs write new values in the middle of a period and check the counter at the old wrap or bottom point before the new period is timed. They also clear or disable in the middle of a period and run a sparse tick pattern, which shows that counting follows the tick and not the clock.

// File: rtl/pwm_align_chan.sv
module pwm_align_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic         pol,
  input  logic         center,
  input  logic         cnt_clr,
  input  logic         per_wr,
  input  logic [W-1:0] per_in,
  input  logic         dty_wr,
  input  logic [W-1:0] dty_in,
  output logic         pwm_out,
  output logic [W-1:0] cnt_out
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt, cnt_nx;
  logic [W-1:0] per_buf, dty_buf, per_act, dty_act;
  logic         down, down_nx, reload;

  always_comb begin
    cnt_nx  = cnt;
    down_nx = down;
    reload  = 1'b0;
    if (!en || cnt_clr) begin
      cnt_nx  = ZERO;
      down_nx = 1'b0;
      reload  = 1'b1;
    end else if (tick) begin
      if (per_act == ZERO) begin
        cnt_nx  = ZERO;
        down_nx = 1'b0;
        reload  = 1'b1;
      end else if (!center) begin
        down_nx = 1'b0;
        if (cnt >= per_act - ONE) begin
          cnt_nx = ZERO;
          reload = 1'b1;
        end else begin
          cnt_nx = cnt + ONE;
        end
      end else if (!down) begin
        if (cnt >= per_act - ONE) begin
          cnt_nx  = per_act;
          down_nx = 1'b1;
        end else begin
          cnt_nx = cnt + ONE;
        end
      end else if (cnt <= ONE) begin
        cnt_nx  = ZERO;
        down_nx = 1'b0;
        reload  = 1'b1;
      end else begin
        cnt_nx = cnt - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= ZERO;
      down    <= 1'b0;
      per_buf <= ZERO;
      dty_buf <= ZERO;
      per_act <= ZERO;
      dty_act <= ZERO;
    end else begin
      cnt  <= cnt_nx;
      down <= down_nx;
      if (per_wr) per_buf <= per_in;
      if (dty_wr) dty_buf <= dty_in;
      if (reload) begin
        per_act <= per_buf;
        dty_act <= dty_buf;
      end
    end
  end

  logic active;
  assign active  = en && (down ? (cnt <= dty_act) : (cnt < dty_act));
  assign pwm_out = active ? pol : !pol;
  assign cnt_out = cnt;

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !cnt_clr && !center && per_act != ZERO && cnt == per_act - ONE) |=> cnt == ZERO);

  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per_act != ZERO) |-> cnt <= per_act);

  p_zero_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dty_act == ZERO) |-> pwm_out == !pol);

  p_swap_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(per_act) && $stable(dty_act)) |-> cnt == ZERO);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_clr) |=> cnt == ZERO);

  p_idle_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == ZERO);

  p_idle_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> pwm_out == !pol);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick && !cnt_clr) |=> $stable(cnt));

endmodule

// File: tb/test_pwm_align_chan.sv
`timescale 1ns/100ps
module test_pwm_align_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, en = 1'b0, pol = 1'b0, center = 1'b0, cnt_clr = 1'b0;
  logic per_wr = 1'b0, dty_wr = 1'b0;
  logic [7:0] per_in = '0, dty_in = '0;
  logic pwm_out;
  logic [7:0] cnt_out;
  int n_chk = 0, n_fail = 0, hi;

  always #2.5 clk = ~clk;

  pwm_align_chan #(.W(8)) i_pwm_align_chan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .pol(pol), .center(center),
    .cnt_clr(cnt_clr), .per_wr(per_wr), .per_in(per_in), .dty_wr(dty_wr),
    .dty_in(dty_in), .pwm_out(pwm_out), .cnt_out(cnt_out));

  typedef struct packed {
    logic       ctr;
    logic       pol;
    logic [7:0] per;
    logic [7:0] dty;
    logic [8:0] len;
    logic [8:0] hi;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TAB [NV] = '{
    '{1'b0, 1'b1, 8'd10,  8'd3,   9'd10,  9'd3},   // R1 R2
    '{1'b0, 1'b0, 8'd10,  8'd3,   9'd10,  9'd7},   // R2 low polarity
    '{1'b0, 1'b1, 8'd120, 8'd60,  9'd120, 9'd60},  // R1 100 kHz case
    '{1'b1, 1'b1, 8'd10,  8'd3,   9'd20,  9'd6},   // R3 R4
    '{1'b1, 1'b0, 8'd10,  8'd3,   9'd20,  9'd14},  // R4 low polarity
    '{1'b0, 1'b1, 8'd8,   8'd8,   9'd8,   9'd8},   // R5 equal
    '{1'b0, 1'b1, 8'd8,   8'd200, 9'd8,   9'd8},   // R5 above
    '{1'b0, 1'b1, 8'd8,   8'd0,   9'd8,   9'd0},   // R5 zero
    '{1'b0, 1'b0, 8'd8,   8'd0,   9'd8,   9'd8},   // R5 zero, low polarity
    '{1'b1, 1'b1, 8'd5,   8'd9,   9'd10,  9'd10},  // R5 center above
    '{1'b1, 1'b1, 8'd1,   8'd1,   9'd2,   9'd2},   // R3 smallest
    '{1'b1, 1'b1, 8'd7,   8'd0,   9'd14,  9'd0}    // R5 center zero
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t t);
    if (t.dty == 0 || t.dty >= t.per) return "R5";
    if (t.ctr) return "R3/R4";
    return "R1/R2";
  endfunction

  task automatic configure(input logic c, input logic p, input logic [7:0] pr, input logic [7:0] dy);
    @(negedge clk);
    en = 1'b0; tick = 1'b1; center = c; pol = p;
    per_in = pr; dty_in = dy; per_wr = 1'b1; dty_wr = 1'b1;
    @(negedge clk);
    per_wr = 1'b0; dty_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 reset counter", int'(cnt_out), 0);
    chk("R10 reset output inactive", int'(pwm_out), 1);
    // R10 buffers start at 0: enabling with no write keeps the counter at 0
    @(negedge clk); en = 1'b1; tick = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset period zero", int'(cnt_out), 0);

    for (int v = 0; v < NV; v++) begin
      configure(TAB[v].ctr, TAB[v].pol, TAB[v].per, TAB[v].dty);
      hi = 0;
      for (int k = 0; k <= int'(TAB[v].len); k++) begin
        #1;
        if (k == 0)
          chk($sformatf("%s vec%0d start level", tag_of(TAB[v]), v), int'(pwm_out),
              int'((TAB[v].dty != 0) ? TAB[v].pol : !TAB[v].pol));
        if (k < int'(TAB[v].len)) hi += int'(pwm_out);
        if (k == int'(TAB[v].len) - 1)
          chk($sformatf("%s vec%0d last count", tag_of(TAB[v]), v), int'(cnt_out),
              TAB[v].ctr ? 1 : int'(TAB[v].per) - 1);
        if (k == int'(TAB[v].len))
          chk($sformatf("%s vec%0d period end", tag_of(TAB[v]), v), int'(cnt_out), 0);
        @(negedge clk);
      end
      chk($sformatf("%s vec%0d high cycles", tag_of(TAB[v]), v), hi, int'(TAB[v].hi));
    end

    // R6 edge-aligned: a write in the middle of the period waits for the wrap
    configure(1'b0, 1'b1, 8'd10, 8'd5);
    per_in = 8'd4; dty_in = 8'd1; hi = 0;
    for (int k = 0; k <= 14; k++) begin
      #1;
      if (k == 9)  chk("R6 old period kept", int'(cnt_out), 9);
      if (k >= 10 && k < 14) hi += int'(pwm_out);
      if (k == 14) chk("R6 new period length", int'(cnt_out), 0);
      per_wr = (k == 3); dty_wr = (k == 3);
      @(negedge clk);
    end
    per_wr = 1'b0; dty_wr = 1'b0;
    chk("R6 new duty", hi, 1);

    // R6 center-aligned: a write on the falling half waits for the bottom
    configure(1'b1, 1'b1, 8'd6, 8'd2);
    per_in = 8'd3; dty_in = 8'd1; hi = 0;
    for (int k = 0; k <= 18; k++) begin
      #1;
      if (k == 9)  chk("R6 center fall continues", int'(cnt_out), 3);
      if (k == 12) chk("R6 center bottom", int'(cnt_out), 0);
      if (k == 15) chk("R6 center new top", int'(cnt_out), 3);
      if (k == 18) chk("R6 center new period end", int'(cnt_out), 0);
      if (k >= 12 && k < 18) hi += int'(pwm_out);
      per_wr = (k == 7); dty_wr = (k == 7);
      @(negedge clk);
    end
    per_wr = 1'b0; dty_wr = 1'b0;
    chk("R6 center new duty", hi, 2);

    // R7 clear in the middle of a period, low polarity
    configure(1'b0, 1'b0, 8'd10, 8'd5);
    for (int k = 0; k <= 8; k++) begin
      #1;
      if (k == 6) chk("R2 inactive level pol0", int'(pwm_out), 1);
      if (k == 7) begin
        chk("R7 counter cleared", int'(cnt_out), 0);
        chk("R7 restart active level", int'(pwm_out), 0);
      end
      if (k == 8) chk("R7 counting resumes", int'(cnt_out), 1);
      cnt_clr = (k == 6);
      @(negedge clk);
    end
    cnt_clr = 1'b0;

    // R8 disable in the middle of a period and stay idle with ticks running
    configure(1'b0, 1'b1, 8'd10, 8'd5);
    for (int k = 0; k <= 10; k++) begin
      #1;
      if (k == 3) chk("R8 running before disable", int'(cnt_out), 3);
      if (k == 5) begin
        chk("R8 counter parked", int'(cnt_out), 0);
        chk("R8 output inactive", int'(pwm_out), 0);
      end
      if (k == 10) chk("R8 still parked", int'(cnt_out), 0);
      if (k == 4) en = 1'b0;
      @(negedge clk);
    end

    // R9 sparse tick: one step every third cycle
    configure(1'b0, 1'b1, 8'd4, 8'd2);
    tick = 1'b0; hi = 0;
    for (int k = 0; k <= 12; k++) begin
      #1;
      if (k < 12) hi += int'(pwm_out);
      if (k == 4)  chk("R9 holds between ticks", int'(cnt_out), 1);
      if (k == 11) chk("R9 last count", int'(cnt_out), 3);
      if (k == 12) chk("R9 period end", int'(cnt_out), 0);
      tick = (k % 3 == 2);
      @(negedge clk);
    end
    chk("R9 high cycles", hi, 6);

    finish_run();
  end
endmodule